// File: doc/BRIEF.md
# Clock Ratio Reprogramming Sequencer

This block is a master on the reconfiguration port of an on-chip clock manager. It changes the manager's multiply and divide factors. A single start pulse, sampled together with the requested multiply and divide factors, starts a fixed sequence. The sequence puts the clock manager into reset, writes the multiply code, writes the divide code, releases the reset, waits for the lock indication and then issues a read of address zero. That read brings the status word back onto the port's data output. Each port access is a one-cycle enable strobe. The sequencer does not start the next access until the port's ready strobe has answered the current one.

The requested factors are range checked before the port is touched. A request whose factors are out of range ends at once with an error and causes no port activity. Each ready wait and the lock wait has its own timeout. An expired wait ends the sequence and reports the phase that stalled. Every request, whether it succeeds or fails, ends with a one-cycle done pulse. The error flag and the error code stay valid until the next request is accepted.

Top module: `clkratio_seq`

## Requirements
- R1: The first cycle after an accepted start raises `cm_rst`. It then stays high for `HOLD_CYC` cycles before the first write strobe, and it stays high through both writes and their ready waits. It is low during the lock wait and the status read.
- R2: The first access is a write (`port_we`=1) to address 0x50. The second access, issued only after the first has been answered, is a write to address 0x52.
- R3: Write data carries the factor minus one in bits [4:0], and every higher data bit is zero. The multiply code goes to 0x50 and the divide code to 0x52.
- R4: Every access is a strobe of exactly one cycle on `port_en`. A ready strobe that arrives in the last cycle of a wait window of `RDY_TIMEOUT` cycles still counts as an answer.
- R5: After `cm_rst` falls, the sequencer waits for `cm_locked` for up to `LOCK_TIMEOUT` cycles. A lock that arrives in the last cycle of that window is accepted.
- R6: The last access of a successful sequence is a read (`port_we`=0) of address 0. Its ready strobe ends the sequence with `done`=1, `err`=0 and `err_code`=0.
- R7: A multiply outside 2..32 or a divide outside 1..32 is rejected. In the cycle after the start, `done`=1, `err`=1 and `err_code`=1. `busy`, `cm_rst` and `port_en` never rise.
- R8: An expired wait ends the sequence with `done`=1, `err`=1 and `cm_rst` low. The code is 2 for a stalled multiply write, 3 for a stalled divide write, 4 for missing lock and 5 for a stalled status read.
- R9: While `busy` is high, start pulses and changes on `mul_req`/`div_req` have no effect. The values captured at acceptance are the ones written, and the sequence timing is unchanged.
- R10: `done` is high for one cycle, in the cycle in which `busy` has just fallen. For a successful request this is `HOLD_CYC`+8 cycles plus the four response delays after the start edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the reconfiguration port |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request pulse, accepted only while idle |
| mul_req | input | FACTOR_W | Requested multiply factor |
| div_req | input | FACTOR_W | Requested divide factor |
| port_en | output | 1 | Access strobe to the reconfiguration port |
| port_we | output | 1 | Write qualifier for the access strobe |
| port_addr | output | ADDR_W | Access address |
| port_wdata | output | DATA_W | Write data |
| port_rdy | input | 1 | Ready strobe answering an access |
| cm_rst | output | 1 | Reset to the clock manager |
| cm_locked | input | 1 | Lock indication from the clock manager |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-request pulse |
| err | output | 1 | Last request failed |
| err_code | output | 3 | 0 none, 1 range, 2..5 timeout phase |

## Verification
In every wait state, the answer (a ready strobe or the lock) can arrive in the same cycle as the expiry of the timeout counter. The bench provokes this by delaying its responder reply by exactly one cycle less than the window, and then by exactly the window. In the first case it expects the sequence to go on with the normal latency. In the second it expects the phase-specific timeout code and the shortened latency. Random requests mix these edge delays with short ones and with factors outside the ranges. Every outcome is judged against an access log and a latency that the bench computes from the requirements.

// File: rtl/clkratio_pkg.sv
package clkratio_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_HOLD,
      ST_WR_MUL,
      ST_WT_MUL,
      ST_WR_DIV,
      ST_WT_DIV,
      ST_WT_LOCK,
      ST_RD_STAT,
      ST_WT_STAT
   } seq_st_e;

   typedef enum logic [2:0] {
      FAIL_NONE    = 3'd0,
      FAIL_RANGE   = 3'd1,
      FAIL_TO_MUL  = 3'd2,
      FAIL_TO_DIV  = 3'd3,
      FAIL_TO_LOCK = 3'd4,
      FAIL_TO_STAT = 3'd5
   } seq_fail_e;

   function automatic int max3(input int a, input int b, input int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/clkratio_range_chk.sv
module clkratio_range_chk #(
   parameter int FACTOR_W = 6,
   parameter int CODE_W   = 5,
   parameter int LO       = 1,
   parameter int HI       = 32
) (
   input  logic [FACTOR_W-1:0] factor,
   output logic                ok,
   output logic [CODE_W-1:0]   code
);
   logic [FACTOR_W-1:0] dec;

   assign ok   = (int'(factor) >= LO) && (int'(factor) <= HI);
   assign dec  = factor - FACTOR_W'(1);
   assign code = dec[CODE_W-1:0];
endmodule

// File: rtl/clkratio_timer.sv
module clkratio_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic [CNT_W-1:0] limit,
   output logic             expired
);
   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (clr)
         cnt <= '0;
      else if (cnt != limit)
         cnt <= cnt + CNT_W'(1);
   end

   assign expired = (cnt == limit);
endmodule

// File: rtl/clkratio_fsm.sv
module clkratio_fsm
   import clkratio_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      start,
   input  logic      req_ok,
   input  logic      rdy,
   input  logic      locked,
   input  logic      expired,
   output seq_st_e   st,
   output logic      tmr_clr,
   output logic      load,
   output logic      fin_ok,
   output logic      fin_err,
   output seq_fail_e fail_code
);
   seq_st_e st_nxt;

   always_comb begin
      st_nxt    = st;
      load      = 1'b0;
      fin_ok    = 1'b0;
      fin_err   = 1'b0;
      fail_code = FAIL_NONE;
      unique case (st)
         ST_IDLE: begin
            if (start) begin
               if (req_ok) begin
                  st_nxt = ST_HOLD;
                  load   = 1'b1;
               end else begin
                  fin_err   = 1'b1;
                  fail_code = FAIL_RANGE;
               end
            end
         end
         ST_HOLD:    if (expired) st_nxt = ST_WR_MUL;
         ST_WR_MUL:  st_nxt = ST_WT_MUL;
         ST_WT_MUL: begin
            if (rdy) st_nxt = ST_WR_DIV;
            else if (expired) begin
               st_nxt = ST_IDLE; fin_err = 1'b1; fail_code = FAIL_TO_MUL;
            end
         end
         ST_WR_DIV:  st_nxt = ST_WT_DIV;
         ST_WT_DIV: begin
            if (rdy) st_nxt = ST_WT_LOCK;
            else if (expired) begin
               st_nxt = ST_IDLE; fin_err = 1'b1; fail_code = FAIL_TO_DIV;
            end
         end
         ST_WT_LOCK: begin
            if (locked) st_nxt = ST_RD_STAT;
            else if (expired) begin
               st_nxt = ST_IDLE; fin_err = 1'b1; fail_code = FAIL_TO_LOCK;
            end
         end
         ST_RD_STAT: st_nxt = ST_WT_STAT;
         ST_WT_STAT: begin
            if (rdy) begin
               st_nxt = ST_IDLE; fin_ok = 1'b1;
            end else if (expired) begin
               st_nxt = ST_IDLE; fin_err = 1'b1; fail_code = FAIL_TO_STAT;
            end
         end
         default: st_nxt = ST_IDLE;
      endcase
   end

   assign tmr_clr = (st_nxt != st);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st <= ST_IDLE;
      else        st <= st_nxt;
   end
endmodule

// File: rtl/clkratio_seq.sv
module clkratio_seq
   import clkratio_pkg::*;
#(
   parameter int FACTOR_W     = 6,
   parameter int ADDR_W       = 7,
   parameter int DATA_W       = 16,
   parameter int CODE_W       = 5,
   parameter int MUL_MIN      = 2,
   parameter int MUL_MAX      = 32,
   parameter int DIV_MIN      = 1,
   parameter int DIV_MAX      = 32,
   parameter int MUL_ADDR     = 'h50,
   parameter int DIV_ADDR     = 'h52,
   parameter int STAT_ADDR    = 0,
   parameter int HOLD_CYC     = 4,
   parameter int RDY_TIMEOUT  = 256,
   parameter int LOCK_TIMEOUT = 4096
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic [FACTOR_W-1:0] mul_req,
   input  logic [FACTOR_W-1:0] div_req,
   output logic                port_en,
   output logic                port_we,
   output logic [ADDR_W-1:0]   port_addr,
   output logic [DATA_W-1:0]   port_wdata,
   input  logic                port_rdy,
   output logic                cm_rst,
   input  logic                cm_locked,
   output logic                busy,
   output logic                done,
   output logic                err,
   output logic [2:0]          err_code
);
   localparam int NF      = 2;
   localparam int LIM_MAX = max3(HOLD_CYC, RDY_TIMEOUT, LOCK_TIMEOUT);
   localparam int CNT_W   = $clog2(LIM_MAX + 1);
   localparam int F_MAX   = (MUL_MAX > DIV_MAX) ? MUL_MAX : DIV_MAX;

   // elaboration-time parameter checks
   if (CODE_W >= DATA_W)                 $error("code field wider than data");
   if (CODE_W > FACTOR_W)                $error("factor narrower than code");
   if (F_MAX > (1 << CODE_W))            $error("factor maximum exceeds code field");
   if ($clog2(F_MAX + 1) > FACTOR_W)     $error("factor input too narrow");
   if (MUL_MIN < 1 || DIV_MIN < 1)       $error("factor minimum must be at least one");
   if (HOLD_CYC < 1)                     $error("hold window must be at least one cycle");
   if (RDY_TIMEOUT < 1 || LOCK_TIMEOUT < 1) $error("timeouts must be positive");
   if (MUL_ADDR >= (1 << ADDR_W) || DIV_ADDR >= (1 << ADDR_W)) $error("address too wide");

   // factor range checks, one per requested factor
   logic [FACTOR_W-1:0] f_in   [NF];
   logic [CODE_W-1:0]   f_code [NF];
   logic [NF-1:0]       f_ok;
   logic                req_ok;

   assign f_in[0] = mul_req;
   assign f_in[1] = div_req;

   for (genvar g = 0; g < NF; g++) begin : g_rng
      localparam int LO = (g == 0) ? MUL_MIN : DIV_MIN;
      localparam int HI = (g == 0) ? MUL_MAX : DIV_MAX;
      clkratio_range_chk #(
         .FACTOR_W(FACTOR_W), .CODE_W(CODE_W), .LO(LO), .HI(HI)
      ) u_rng (
         .factor(f_in[g]), .ok(f_ok[g]), .code(f_code[g])
      );
   end

   assign req_ok = &f_ok;

   // sequencer and shared wait timer
   seq_st_e          st;
   seq_fail_e        fail_code;
   logic             tmr_clr, load, fin_ok, fin_err, expired;
   logic [CNT_W-1:0] tmr_limit;

   clkratio_fsm u_fsm (
      .clk(clk), .rst_n(rst_n), .start(start), .req_ok(req_ok),
      .rdy(port_rdy), .locked(cm_locked), .expired(expired),
      .st(st), .tmr_clr(tmr_clr), .load(load),
      .fin_ok(fin_ok), .fin_err(fin_err), .fail_code(fail_code)
   );

   always_comb begin
      unique case (st)
         ST_HOLD:    tmr_limit = CNT_W'(HOLD_CYC - 1);
         ST_WT_LOCK: tmr_limit = CNT_W'(LOCK_TIMEOUT - 1);
         default:    tmr_limit = CNT_W'(RDY_TIMEOUT - 1);
      endcase
   end

   clkratio_timer #(.CNT_W(CNT_W)) u_tmr (
      .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .limit(tmr_limit), .expired(expired)
   );

   // captured codes and result flags
   logic [CODE_W-1:0] mul_code, div_code;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mul_code <= '0;
         div_code <= '0;
      end else if (load) begin
         mul_code <= f_code[0];
         div_code <= f_code[1];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done     <= 1'b0;
         err      <= 1'b0;
         err_code <= FAIL_NONE;
      end else begin
         done <= fin_ok | fin_err;
         if (load) begin
            err      <= 1'b0;
            err_code <= FAIL_NONE;
         end else if (fin_err) begin
            err      <= 1'b1;
            err_code <= fail_code;
         end else if (fin_ok) begin
            err      <= 1'b0;
            err_code <= FAIL_NONE;
         end
      end
   end

   // port and reset drive, decoded from the state register
   assign port_en = (st == ST_WR_MUL) || (st == ST_WR_DIV) || (st == ST_RD_STAT);
   assign port_we = (st == ST_WR_MUL) || (st == ST_WR_DIV);
   assign cm_rst  = (st == ST_HOLD) || (st == ST_WR_MUL) || (st == ST_WT_MUL) ||
                    (st == ST_WR_DIV) || (st == ST_WT_DIV);
   assign busy    = (st != ST_IDLE);

   always_comb begin
      port_wdata = '0;
      unique case (st)
         ST_WR_MUL: begin
            port_addr               = ADDR_W'(MUL_ADDR);
            port_wdata[CODE_W-1:0]  = mul_code;
         end
         ST_WR_DIV: begin
            port_addr               = ADDR_W'(DIV_ADDR);
            port_wdata[CODE_W-1:0]  = div_code;
         end
         default:   port_addr = ADDR_W'(STAT_ADDR);
      endcase
   end
endmodule

// File: rtl/clkratio_seq_chk.sv
module clkratio_seq_chk #(
   parameter int ADDR_W    = 7,
   parameter int DATA_W    = 16,
   parameter int CODE_W    = 5,
   parameter int MUL_ADDR  = 'h50,
   parameter int DIV_ADDR  = 'h52,
   parameter int STAT_ADDR = 0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              port_en,
   input logic              port_we,
   input logic [ADDR_W-1:0] port_addr,
   input logic [DATA_W-1:0] port_wdata,
   input logic              cm_rst,
   input logic              busy,
   input logic              done,
   input logic              err,
   input logic [2:0]        err_code
);
   assert_rst_in_seq_R1: assert property (@(posedge clk) disable iff (!rst_n)
      cm_rst |-> busy);
   assert_write_under_rst_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (port_en && port_we) |-> cm_rst);
   assert_write_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (port_en && port_we) |->
         (port_addr == ADDR_W'(MUL_ADDR) || port_addr == ADDR_W'(DIV_ADDR)));
   assert_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (port_en && port_we) |-> (port_wdata[DATA_W-1:CODE_W] == '0));
   assert_strobe_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
      port_en |=> !port_en);
   assert_status_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (port_en && !port_we) |-> (port_addr == ADDR_W'(STAT_ADDR) && !cm_rst));
   assert_reject_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (done && err && err_code == 3'd1) |-> !$past(busy));
   assert_accept_from_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start));
   assert_done_after_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
endmodule

bind clkratio_seq clkratio_seq_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CODE_W(CODE_W),
   .MUL_ADDR(MUL_ADDR), .DIV_ADDR(DIV_ADDR), .STAT_ADDR(STAT_ADDR)
) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .port_en(port_en), .port_we(port_we),
   .port_addr(port_addr), .port_wdata(port_wdata), .cm_rst(cm_rst), .busy(busy),
   .done(done), .err(err), .err_code(err_code)
);

// File: tb/clkratio_seq_test.sv
`timescale 1ns/1ps
module clkratio_seq_test;
   localparam int HC = 3;
   localparam int RT = 8;
   localparam int LT = 20;
   localparam int NEVER = 1000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [5:0]  mul_req = '0, div_req = '0;
   logic        port_en, port_we, port_rdy = 1'b0;
   logic [6:0]  port_addr;
   logic [15:0] port_wdata;
   logic        cm_rst, cm_locked = 1'b0;
   logic        busy, done, err;
   logic [2:0]  err_code;

   int checks = 0, errors = 0, cyc = 0;

   always #2 clk = ~clk;

   clkratio_seq #(.HOLD_CYC(HC), .RDY_TIMEOUT(RT), .LOCK_TIMEOUT(LT)) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .mul_req(mul_req), .div_req(div_req),
      .port_en(port_en), .port_we(port_we), .port_addr(port_addr),
      .port_wdata(port_wdata), .port_rdy(port_rdy), .cm_rst(cm_rst),
      .cm_locked(cm_locked), .busy(busy), .done(done), .err(err), .err_code(err_code)
   );

   // responder, lock model and access log, all at the falling edge
   int  dly[3];
   int  lock_dly = 0, lcnt = 0, pend_cnt = 0, nacc = 0;
   bit  pending = 0;
   logic [6:0]  lg_addr[8];
   logic [15:0] lg_data[8];
   logic        lg_we[8], lg_rst[8];

   always @(negedge clk) begin
      port_rdy = 1'b0;
      if (pending) begin
         if (pend_cnt == 0) begin port_rdy = 1'b1; pending = 0; end
         else pend_cnt--;
      end
      if (port_en) begin
         pending  = 1;
         pend_cnt = (port_addr == 7'h50) ? dly[0] : (port_addr == 7'h52) ? dly[1] : dly[2];
         if (nacc < 8) begin
            lg_addr[nacc] = port_addr; lg_data[nacc] = port_wdata;
            lg_we[nacc] = port_we; lg_rst[nacc] = cm_rst;
         end
         nacc++;
      end
      if (cm_rst) begin cm_locked = 1'b0; lcnt = 0; end
      else begin
         if (lcnt == lock_dly) cm_locked = 1'b1;
         if (lcnt < 100000) lcnt++;
      end
   end

   task automatic summary();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         errors++;
         $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
         summary();
         $finish;
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic bit in_range(input int m, input int d);
      return (m >= 2 && m <= 32 && d >= 1 && d <= 32);
   endfunction

   function automatic int exp_code(input int m, input int d, input int dm, input int dd,
                                   input int dl, input int ds);
      if (!in_range(m, d)) return 1;
      if (dm >= RT) return 2;
      if (dd >= RT) return 3;
      if (dl >= LT) return 4;
      if (ds >= RT) return 5;
      return 0;
   endfunction

   function automatic int exp_nacc(input int code);
      case (code)
         1: return 0;
         2: return 1;
         3, 4: return 2;
         default: return 3;
      endcase
   endfunction

   function automatic int exp_lat(input int m, input int d, input int dm, input int dd,
                                  input int dl, input int ds);
      int t;
      if (!in_range(m, d)) return 1;
      if (dm >= RT) return HC + 2 + RT;
      t = HC + 2 + dm;
      if (dd >= RT) return t + 2 + RT;
      t = t + 2 + dd;
      if (dl >= LT) return t + 1 + LT;
      t = t + 1 + dl;
      if (ds >= RT) return t + 2 + RT;
      t = t + 2 + ds;
      return t + 1;
   endfunction

   task automatic run(input int m, input int d, input int dm, input int dd,
                      input int dl, input int ds, input bit poke);
      int n, code, na, lat;
      bit ok_saw_rst;
      dly[0] = dm; dly[1] = dd; dly[2] = ds; lock_dly = dl;
      pending = 0; nacc = 0;
      code = exp_code(m, d, dm, dd, dl, ds);
      na   = exp_nacc(code);
      lat  = exp_lat(m, d, dm, dd, dl, ds);
      @(negedge clk);
      mul_req = 6'(m); div_req = 6'(d); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      n = 1;
      ok_saw_rst = cm_rst;
      // R1 / R7: reset rises in the first cycle only for an accepted request
      chk(cm_rst == (code != 1), "R1/R7 cm_rst after start", cm_rst, code != 1);
      while (!done && n < 3000) begin
         if (poke && n == 2) begin
            start = 1'b1; mul_req = 6'((m % 30) + 3); div_req = 6'((d % 30) + 2);
         end
         if (poke && n == 3) start = 1'b0;
         if (n == HC && code != 1)
            chk(cm_rst && !port_en, "R1 reset hold before first write", cm_rst, 1);
         @(negedge clk);
         n++;
      end
      chk(n == lat, poke ? "R9 latency with ignored start" : "R10 done latency", n, lat);
      chk(!busy, "R10 busy low at done", busy, 0);
      chk(err == (code != 0), "R8 err flag", err, code != 0);
      chk(int'(err_code) == code, code == 1 ? "R7 range code" : "R8 result code",
          err_code, code);
      chk(nacc == na, code == 1 ? "R7 no port activity" : "R4 access count", nacc, na);
      for (int i = 0; i < na && i < 3; i++) begin
         int ea;
         ea = (i == 0) ? 'h50 : (i == 1) ? 'h52 : 0;
         chk(int'(lg_addr[i]) == ea, i == 2 ? "R6 status address" : "R2 write address",
             lg_addr[i], ea);
         chk(lg_we[i] == (i < 2), i == 2 ? "R6 read qualifier" : "R2 write qualifier",
             lg_we[i], i < 2);
         chk(lg_rst[i] == (i < 2), "R1 reset level at access", lg_rst[i], i < 2);
         if (i < 2) begin
            int ed;
            ed = (i == 0) ? m - 1 : d - 1;
            chk(int'(lg_data[i]) == ed, poke ? "R9 captured factor" : "R3 factor code",
                lg_data[i], ed);
         end
      end
      if (code >= 2) chk(!cm_rst, "R8 reset released after timeout", cm_rst, 0);
      if (code == 0) chk(!cm_rst, "R5 reset low after lock", cm_rst, 0);
      @(negedge clk);
      chk(!done, "R10 done single cycle", done, 0);
      chk(nacc == na, "R4 no access after done", nacc, na);
      repeat (2) @(negedge clk);
   endtask

   function automatic int rnd_dly(input int lim);
      int r;
      r = int'($urandom % 16);
      if (r < 11) return r % 5;
      if (r < 13) return lim - 1;
      if (r == 13) return lim;
      return r % 3;
   endfunction

   initial begin
      void'($urandom(32'd20240611));
      dly[0] = 0; dly[1] = 0; dly[2] = 0;
      repeat (3) @(negedge clk);
      chk(!busy && !done && !cm_rst && !port_en && !err, "R10 reset state",
          {busy, done, cm_rst, port_en, err}, 0);
      chk(err_code == 3'd0, "R8 reset code", err_code, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // directed corners
      run(2, 1, 0, 0, 0, 0, 0);              // R3 minimum factors
      run(32, 32, 1, 2, 3, 1, 0);            // R3 maximum factors
      run(1, 5, 0, 0, 0, 0, 0);              // R7 multiply below range
      run(33, 5, 0, 0, 0, 0, 0);             // R7 multiply above range
      run(8, 0, 0, 0, 0, 0, 0);              // R7 divide below range
      run(8, 33, 0, 0, 0, 0, 0);             // R7 divide above range
      run(5, 3, RT - 1, RT - 1, 0, RT - 1, 0); // R4 ready on last window cycle
      run(5, 3, NEVER, 0, 0, 0, 0);          // R8 multiply write stalls
      run(5, 3, 0, RT, 0, 0, 0);             // R8 divide write stalls at window
      run(5, 3, 0, 0, LT - 1, 0, 0);         // R5 lock on last window cycle
      run(5, 3, 0, 0, LT, 0, 0);             // R5/R8 lock missing
      run(5, 3, 0, 0, 2, RT, 0);             // R6/R8 status read stalls
      run(12, 7, 2, 1, 4, 0, 1);             // R9 start and factors changed while busy
      run(4, 4, 0, 0, 0, 0, 0);              // R6 recovery after failures

      // random mix
      for (int k = 0; k < 40; k++) begin
         int m, d;
         m = int'($urandom % 36);
         d = int'($urandom % 36);
         run(m, d, rnd_dly(RT), rnd_dly(RT), rnd_dly(LT), rnd_dly(RT), bit'($urandom % 2));
      end

      summary();
      $finish;
   end
endmodule